// File: doc/BRIEF.md
# Timer Output Compare Channel Bank

This block holds eight output compare channels that all watch one shared 16-bit counter. The counter advances from the module clock through a power-of-two prescaler, and only while a run bit is set. Each channel has a 16-bit compare value. When the counter steps onto that value, a channel in compare mode raises its event flag and applies a 2-bit pin action to its output: toggle, drive low, drive high, or leave the pin alone. A pin is driven only when its channel is in compare mode and its action is not "none". A flag together with its interrupt enable bit raises that channel's interrupt line.

Software makes periodic waveforms by adding a half-period to the compare value after each match. Equal additions give a 50% square wave. Alternating two different additions gives an asymmetric duty cycle. Because a match is equality against a free-running counter, a compare value that the counter has already passed does not fire until the counter wraps.

The register port is a plain single-cycle write strobe with a combinational read. It uses 4-bit word addresses and 16-bit data:

| Address | Register |
|---|---|
| 0 | Control: bit 0 is run, bits 3:1 are the prescale code |
| 1 | Mode: bit n set puts channel n in compare mode |
| 2 | Low action register: channels 0 to 3 |
| 3 | High action register: channels 4 to 7 |
| 4 | Flags: write one to clear |
| 5 | Interrupt enable |
| 6 | Counter, read only |
| 8 to 15 | Compare value of channel n at address 8+n |

Top module: `oc_bank`

## Requirements
- R1: After reset, every register reads zero, the counter reads zero, and all pins, pin enables and interrupt lines are low.
- R2: The counter advances by one every 2^code clock cycles while control bit 0 (run) is 1, where code is control bits 3:1. The counter holds its value while run is 0.
- R3: A channel whose bit in the mode register (address 1) is 0 never sets its flag, never changes its pin and never drives its pin, even when the counter reaches its compare value.
- R4: On the clock edge where the counter steps onto compare value n, flag bit n (address 4) becomes 1 and the pin action takes effect on that same edge.
- R5: Channel n's action field is bits 2n+1:2n of address 2 for n < 4, and bits 2(n-4)+1:2(n-4) of address 3 for n ≥ 4. The codes are: 00 leaves the pin unchanged, 01 toggles it, 10 drives it low, 11 drives it high.
- R6: Writing a 1 to a flag bit clears that flag. Writing 0 leaves it set. A match in the same cycle as a clear leaves the flag set.
- R7: Interrupt line n equals flag n AND bit n of the interrupt enable register (address 5).
- R8: With a prescale divide greater than 1, a match acts once per counter increment. The pin does not change again while the counter rests on the compare value.
- R9: A compare write takes effect from the next counter value. Writing a value the counter has already passed produces no match before wrap.
- R10: Adding a half-period to the compare value after each match produces a toggling pin whose transitions fall exactly at the programmed counter values. This holds for equal and for unequal half-periods.
- R11: Pin enable n is 1 exactly when channel n is in compare mode and its action code is not 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Combinational read data for reg_addr |
| oc_pin | output | 8 | Per-channel compare output level |
| oc_oe | output | 8 | Per-channel pin drive enable |
| oc_irq | output | 8 | Per-channel interrupt request |

## Verification
The bench targets several errors:
- Off-by-one timing, where the pin or flag moves one counter value early or late. The bench samples at both the value before the compare value and at the compare value itself.
- Repeated toggling under a prescaler. A design that matched on every clock rather than every increment would flip the pin back while the counter rests on the compare value.
- A stale compare value behind the counter. A design comparing with "greater or equal" would fire at once.
- A write of zero to the flag register. A design that cleared on any write would drop the flag.
- A disabled channel. A design that ignored the mode bit would set its flag or move its pin.
- Wrong action-field packing. This would make one channel respond to another's code.

// File: rtl/oc_pkg.sv
package oc_pkg;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'b00,
    ACT_TOGGLE = 2'b01,
    ACT_LOW    = 2'b10,
    ACT_HIGH   = 2'b11
  } oc_act_e;

  // register word addresses; compare values start at 1 << (AW-1)
  localparam int A_CTRL   = 0;
  localparam int A_MODE   = 1;
  localparam int A_ACT_LO = 2;
  localparam int A_ACT_HI = 3;
  localparam int A_FLAG   = 4;
  localparam int A_IEN    = 5;
  localparam int A_COUNT  = 6;

  // channels packed into each action register
  localparam int ACT_PER_REG = 4;

endpackage

// File: rtl/oc_prescaler.sv
module oc_prescaler #(
  parameter int CW    = 16,
  parameter int PRE_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PRE_W-1:0] pre_code,
  output logic             tick,
  output logic [CW-1:0]    count,
  output logic [CW-1:0]    count_next
);
  localparam int DIV_W = (1 << PRE_W) - 1;

  logic [DIV_W-1:0] pre_q;
  logic [DIV_W-1:0] mask;
  logic [CW-1:0]    count_q;

  assign mask       = DIV_W'((32'd1 << pre_code) - 32'd1);
  assign tick       = run && ((pre_q & mask) == mask);
  assign count_next = count_q + 1'b1;
  assign count      = count_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pre_q <= '0;
    else if (run) pre_q <= pre_q + 1'b1;
    else          pre_q <= '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count_q <= '0;
    else if (tick) count_q <= count_next;
  end

  // R2: stopped counter holds
  p_hold_stopped_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(count_q));
  // R2: an increment moves exactly one step
  p_single_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> count_q == CW'($past(count_q) + 1'b1));
  // R2: between increments the value rests
  p_rest_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(count_q));

endmodule

// File: rtl/oc_channel.sv
module oc_channel import oc_pkg::*; #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [CW-1:0] count_next,
  input  logic [CW-1:0] cmp,
  input  logic          mode_en,
  input  logic [1:0]    act,
  input  logic          flag_clr,
  output logic          flag,
  output logic          pin,
  output logic          oe
);
  oc_act_e act_e;
  logic    hit;
  logic    flag_q;
  logic    pin_q;

  assign act_e = oc_act_e'(act);
  // one evaluation per increment, against the value being entered
  assign hit   = tick && mode_en && (count_next == cmp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag_q <= 1'b0;
    else if (hit)      flag_q <= 1'b1;
    else if (flag_clr) flag_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= 1'b0;
    else if (hit) begin
      unique case (act_e)
        ACT_TOGGLE: pin_q <= ~pin_q;
        ACT_LOW:    pin_q <= 1'b0;
        ACT_HIGH:   pin_q <= 1'b1;
        default:    pin_q <= pin_q;
      endcase
    end
  end

  assign flag = flag_q;
  assign pin  = pin_q;
  assign oe   = mode_en && (act_e != ACT_NONE);

  // R3: a disabled channel leaves its pin and flag alone
  p_mode_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_en |=> $stable(pin_q) && !$rose(flag_q));
  // R4 and R6: a match always leaves the flag set, clear or not
  p_match_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag_q);
  // R6: a clear without a match drops the flag
  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !hit) |=> !flag_q);
  // R5: the none code never moves the pin
  p_none_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (act_e == ACT_NONE) |=> $stable(pin_q));
  // R5: a toggle match inverts the pin
  p_toggle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && act_e == ACT_TOGGLE) |=> pin_q != $past(pin_q));
  // R8: no increment, no pin change
  p_once_per_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(pin_q));

endmodule

// File: rtl/oc_regs.sv
module oc_regs import oc_pkg::*; #(
  parameter int NCH   = 8,
  parameter int CW    = 16,
  parameter int AW    = 4,
  parameter int PRE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     addr,
  input  logic [CW-1:0]     wdata,
  output logic [CW-1:0]     rdata,
  input  logic [CW-1:0]     count,
  input  logic [NCH-1:0]    flags,
  output logic              run,
  output logic [PRE_W-1:0]  pre_code,
  output logic [NCH-1:0]    mode,
  output logic [2*NCH-1:0]  act,
  output logic [NCH-1:0]    ien,
  output logic [NCH*CW-1:0] cmp_flat,
  output logic [NCH-1:0]    flag_clr
);
  localparam int ABITS    = 2 * NCH;
  localparam int LO_BITS  = 2 * ACT_PER_REG;
  localparam int HI_BITS  = ABITS - LO_BITS;
  localparam int CMP_BASE = 1 << (AW - 1);

  logic              run_q;
  logic [PRE_W-1:0]  pre_q;
  logic [NCH-1:0]    mode_q;
  logic [ABITS-1:0]  act_q;
  logic [NCH-1:0]    ien_q;
  logic [CW-1:0]     cmp_q [NCH];
  logic              unused_wdata;

  function automatic logic wr_at(input int a);
    return wr_en && (addr == AW'(a));
  endfunction

  assign unused_wdata = ^wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      pre_q  <= '0;
      mode_q <= '0;
      act_q  <= '0;
      ien_q  <= '0;
    end else begin
      if (wr_at(A_CTRL)) begin
        run_q <= wdata[0];
        pre_q <= wdata[PRE_W:1];
      end
      if (wr_at(A_MODE))   mode_q <= wdata[NCH-1:0];
      if (wr_at(A_ACT_LO)) act_q[LO_BITS-1:0] <= wdata[LO_BITS-1:0];
      if (wr_at(A_ACT_HI)) act_q[ABITS-1:LO_BITS] <= wdata[HI_BITS-1:0];
      if (wr_at(A_IEN))    ien_q <= wdata[NCH-1:0];
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_cmp
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cmp_q[i] <= '0;
      else if (wr_at(CMP_BASE + i)) cmp_q[i] <= wdata;
    end
    assign cmp_flat[i*CW +: CW] = cmp_q[i];
  end

  assign flag_clr = wr_at(A_FLAG) ? wdata[NCH-1:0] : '0;

  always_comb begin
    rdata = '0;
    if (addr[AW-1]) begin
      for (int i = 0; i < NCH; i++)
        if (addr[AW-2:0] == (AW-1)'(i)) rdata = cmp_q[i];
    end else begin
      case (int'(addr))
        A_CTRL:   rdata = CW'({pre_q, run_q});
        A_MODE:   rdata = CW'(mode_q);
        A_ACT_LO: rdata = CW'(act_q[LO_BITS-1:0]);
        A_ACT_HI: rdata = CW'(act_q[ABITS-1:LO_BITS]);
        A_FLAG:   rdata = CW'(flags);
        A_IEN:    rdata = CW'(ien_q);
        A_COUNT:  rdata = count;
        default:  rdata = '0;
      endcase
    end
  end

  assign run      = run_q;
  assign pre_code = pre_q;
  assign mode     = mode_q;
  assign act      = act_q;
  assign ien      = ien_q;

  // R5: a low action write never disturbs the high channels' fields
  p_act_lo_isolated_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_at(A_ACT_LO) |=> $stable(act_q[ABITS-1:LO_BITS]));
  // R6: a clear strobe only arises from a flag register write
  p_clear_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr != '0) |-> (wr_en && addr == AW'(A_FLAG)));

endmodule

// File: rtl/oc_bank.sv
module oc_bank import oc_pkg::*; #(
  parameter int NCH   = 8,
  parameter int CW    = 16,
  parameter int AW    = 4,
  parameter int PRE_W = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_wr,
  input  logic [AW-1:0]  reg_addr,
  input  logic [CW-1:0]  reg_wdata,
  output logic [CW-1:0]  reg_rdata,
  output logic [NCH-1:0] oc_pin,
  output logic [NCH-1:0] oc_oe,
  output logic [NCH-1:0] oc_irq
);
  logic              run;
  logic [PRE_W-1:0]  pre_code;
  logic              tick;
  logic [CW-1:0]     count;
  logic [CW-1:0]     count_next;
  logic [NCH-1:0]    mode;
  logic [2*NCH-1:0]  act;
  logic [NCH-1:0]    ien;
  logic [NCH*CW-1:0] cmp_flat;
  logic [NCH-1:0]    flag_clr;
  logic [NCH-1:0]    flags;

  oc_prescaler #(.CW(CW), .PRE_W(PRE_W)) u_pre (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .pre_code   (pre_code),
    .tick       (tick),
    .count      (count),
    .count_next (count_next)
  );

  oc_regs #(.NCH(NCH), .CW(CW), .AW(AW), .PRE_W(PRE_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (reg_wr),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .rdata    (reg_rdata),
    .count    (count),
    .flags    (flags),
    .run      (run),
    .pre_code (pre_code),
    .mode     (mode),
    .act      (act),
    .ien      (ien),
    .cmp_flat (cmp_flat),
    .flag_clr (flag_clr)
  );

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    oc_channel #(.CW(CW)) u_ch (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick),
      .count_next (count_next),
      .cmp        (cmp_flat[n*CW +: CW]),
      .mode_en    (mode[n]),
      .act        (act[2*n +: 2]),
      .flag_clr   (flag_clr[n]),
      .flag       (flags[n]),
      .pin        (oc_pin[n]),
      .oe         (oc_oe[n])
    );
  end

  assign oc_irq = flags & ien;

  // R7: no request without both its flag and its enable
  p_irq_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((oc_irq & ~flags) == '0) && ((oc_irq & ~ien) == '0));
  // R11: a driven pin always belongs to a compare-mode channel
  p_oe_mode_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (oc_oe & ~mode) == '0);
  // R4: flags only rise on a counter increment
  p_flag_on_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> (flags & ~$past(flags)) == '0);

endmodule

// File: tb/oc_bank_tb_top.sv
module oc_bank_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 8;
  localparam int CW  = 16;
  localparam int AW  = 4;

  // vector: {channel[2:0], action[1:0], delta[7:0], expected pin}
  localparam int NVEC = 8;
  localparam logic [13:0] VEC [NVEC] = '{
    {3'd2, 2'b01, 8'd10, 1'b1},
    {3'd2, 2'b01, 8'd7,  1'b0},
    {3'd5, 2'b11, 8'd8,  1'b1},
    {3'd5, 2'b10, 8'd9,  1'b0},
    {3'd5, 2'b10, 8'd6,  1'b0},
    {3'd0, 2'b00, 8'd6,  1'b0},
    {3'd7, 2'b11, 8'd7,  1'b1},
    {3'd7, 2'b00, 8'd8,  1'b1}
  };

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           reg_wr = 1'b0;
  logic [AW-1:0]  reg_addr = '0;
  logic [CW-1:0]  reg_wdata = '0;
  logic [CW-1:0]  reg_rdata;
  logic [NCH-1:0] oc_pin, oc_oe, oc_irq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [15:0]    act_sh = '0;
  logic [NCH-1:0] pin_exp = '0;

  oc_bank dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .oc_pin(oc_pin), .oc_oe(oc_oe), .oc_irq(oc_irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      finish_run();
    end
  end

  task automatic chk(input logic ok, input string tag, input int act_v, input int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act_v, exp_v);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = AW'(a); reg_wdata = CW'(d);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [CW-1:0] d);
    reg_addr = AW'(a);
    #1 d = reg_rdata;
  endtask

  task automatic rd_count(output logic [CW-1:0] d);
    rd(6, d);
  endtask

  task automatic wait_count(input logic [CW-1:0] v);
    logic [CW-1:0] c;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      rd_count(c);
      if (c == v) return;
    end
    chk(1'b0, "wait_count", int'(c), int'(v));
  endtask

  task automatic set_act(input int ch, input logic [1:0] code);
    act_sh[2*ch +: 2] = code;
    if (ch < 4) wr(2, int'(act_sh[7:0]));
    else        wr(3, int'(act_sh[15:8]));
  endtask

  initial begin
    logic [CW-1:0] d, c, nxt, cmp;
    int ch;
    logic [1:0] a;
    int delta;
    logic e;

    repeat (3) @(negedge clk);
    // R1: reset values
    for (int r = 0; r < 16; r++) begin
      rd(r, d);
      chk(d == 0, $sformatf("R1 reg %0d", r), int'(d), 0);
    end
    chk(oc_pin == 0 && oc_oe == 0 && oc_irq == 0, "R1 outputs", int'({oc_pin, oc_oe, oc_irq}), 0);
    rst_n = 1'b1;

    wr(1, 8'hBF);           // all channels but 6 in compare mode
    wr(0, 1);               // run, divide by 1

    // table of action vectors: R4 R5
    for (int v = 0; v < NVEC; v++) begin
      ch = int'(VEC[v][13:11]); a = VEC[v][10:9];
      delta = int'(VEC[v][8:1]); e = VEC[v][0];
      set_act(ch, a);
      @(negedge clk); rd_count(c);
      cmp = c + CW'(delta);
      wr(8 + ch, int'(cmp));
      wait_count(cmp - 1'b1);
      chk(oc_pin[ch] == pin_exp[ch], $sformatf("R4 v%0d pin early", v), int'(oc_pin[ch]), int'(pin_exp[ch]));
      rd(4, d);
      chk(d[ch] == 1'b0, $sformatf("R4 v%0d flag early", v), int'(d[ch]), 0);
      wait_count(cmp);
      chk(oc_pin[ch] == e, $sformatf("R5 v%0d pin at match", v), int'(oc_pin[ch]), int'(e));
      rd(4, d);
      chk(d[ch] == 1'b1, $sformatf("R4 v%0d flag at match", v), int'(d[ch]), 1);
      pin_exp[ch] = e;
      wr(4, 1 << ch);
      @(negedge clk); rd(4, d);
      chk(d == 0, $sformatf("R6 v%0d flag cleared", v), int'(d), 0);
    end

    // R7 interrupt gating and R6 zero write
    wr(5, 8'h04);
    set_act(2, 2'b01);
    @(negedge clk); rd_count(c);
    cmp = c + 16'd8;
    wr(10, int'(cmp));
    wait_count(cmp);
    chk(oc_irq == 8'h04, "R7 irq on enabled flag", int'(oc_irq), 4);
    wr(4, 0);
    rd(4, d);
    chk(d == 16'h0004, "R6 zero write keeps flag", int'(d), 4);
    wr(5, 0);
    chk(oc_irq == 0, "R7 irq masked", int'(oc_irq), 0);
    wr(4, 8'h04);
    pin_exp[2] = ~pin_exp[2];

    // R9 compare value already passed
    @(negedge clk); rd_count(c);
    wr(11, int'(c - 16'd1));
    set_act(3, 2'b11);
    repeat (20) @(negedge clk);
    rd(4, d);
    chk(d[3] == 1'b0, "R9 no retroactive flag", int'(d[3]), 0);
    chk(oc_pin[3] == 1'b0, "R9 no retroactive pin", int'(oc_pin[3]), 0);

    // R3 channel outside compare mode
    set_act(6, 2'b11);
    @(negedge clk); rd_count(c);
    cmp = c + 16'd6;
    wr(14, int'(cmp));
    wait_count(cmp + 1'b1);
    rd(4, d);
    chk(d[6] == 1'b0 && oc_pin[6] == 1'b0, "R3 disabled channel idle",
        int'({d[6], oc_pin[6]}), 0);

    // R11 pin enables: modes BF, actions on 2,3,5,6 (7 and 0 none)
    chk(oc_oe == 8'h2C, "R11 pin enables", int'(oc_oe), 8'h2C);

    // R10 square and asymmetric waves on channel 3
    set_act(3, 2'b01);
    @(negedge clk); rd_count(c);
    nxt = c + 16'd9;
    wr(11, int'(nxt));
    for (int k = 0; k < 6; k++) begin
      wait_count(nxt - 1'b1);
      chk(oc_pin[3] == k[0], $sformatf("R10 half %0d before edge", k), int'(oc_pin[3]), int'(k[0]));
      wait_count(nxt);
      chk(oc_pin[3] == ~k[0], $sformatf("R10 half %0d at edge", k), int'(oc_pin[3]), int'(~k[0]));
      nxt = nxt + ((k < 2) ? 16'd9 : (k[0] ? 16'd11 : 16'd6));
      wr(11, int'(nxt));
      wr(4, 8'h08);
    end

    // R2 prescale code 2: one step every 4 cycles
    wr(0, (2 << 1) | 1);
    @(negedge clk); rd_count(c);
    wait_count(c + 16'd1);
    begin
      int n = 0;
      do begin
        @(negedge clk); rd_count(d); n++;
      end while (d == c + 16'd1 && n < 20);
      chk(n == 4, "R2 divide by four spacing", n, 4);
    end

    // R8 single action while the counter rests on the match value
    set_act(1, 2'b01);
    @(negedge clk); rd_count(c);
    cmp = c + 16'd4;
    wr(9, int'(cmp));
    wait_count(cmp);
    chk(oc_pin[1] == 1'b1, "R8 toggled at match", int'(oc_pin[1]), 1);
    repeat (2) @(negedge clk);
    rd_count(d);
    chk(oc_pin[1] == 1'b1 && d == cmp, "R8 no repeat toggle", int'({d, oc_pin[1]}), int'({cmp, 1'b1}));

    // R2 stopped counter holds
    wr(0, 0);
    rd_count(c);
    repeat (6) @(negedge clk);
    rd_count(d);
    chk(d == c, "R2 counter frozen", int'(d), int'(c));

    finish_run();
  end
endmodule